// File: doc/BRIEF.md
# Steering Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and presents them to a processor core on two request lines: a normal request and a fast request. On every clock it captures the source vector into a raw pending register. A per-bit enable register gates each pending source. A per-bit steering register then sends each enabled source to exactly one of the two request lines. A set steering bit selects the fast line and a clear bit selects the normal line.

Software reaches the block through a simple word-wide register bus with a select, a write strobe, a byte offset and write data. Read data is combinational while a read is selected. Three views are read-only and are formed from stored state at read time: raw pending, normal-routed pending and fast-routed pending. The enable, steering and control words are plain read/write storage. The request outputs come straight from flip-flops. They change exactly one clock after the source vector or a configuration write that causes the change.

Several source positions are fixed by the system map. These are the real-time-clock alarm (bit 31), the real-time-clock tick (bit 30), the four timer match events (bits 26 to 29, match 0 at bit 26) and the serial port (bit 17). All other bits are general-purpose lines.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable, steering, control and raw pending words are all zero, and both request outputs are low.
- R2: A read at offset 0x20 returns the source vector that was present at the previous rising clock edge.
- R3: A read at offset 0x00 returns enable AND raw pending AND NOT steering (normal-routed view).
- R4: A read at offset 0x10 returns enable AND raw pending AND steering (fast-routed view).
- R5: The normal request output is high exactly when the normal-routed view is non-zero, and the fast request output is high exactly when the fast-routed view is non-zero. Both outputs follow a source or configuration change after exactly one clock.
- R6: Offsets 0x04 (enable), 0x08 (steering) and 0x0C (control) are full 32-bit read/write words. A write with bus_sel and bus_we high takes effect at that clock edge.
- R7: Writes to offsets 0x00, 0x10 and 0x20 change no stored word.
- R8: A read at any other offset, including an offset that is not word-aligned, returns zero, and a write there changes nothing. bus_rdata is zero unless a read is selected.
- R9: The fixed system source positions (bits 31, 30, 26 to 29 and 17) are steered independently, like any other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Level interrupt source vector |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero unless a read is selected |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The bench mixes random source vectors and random configuration traffic with directed corner cases. Those cases cover a fully enabled vector steered all to one line, a vector fully masked off, single fixed-position sources, and writes aimed at the read-only views, at the gaps in the map and at misaligned offsets. A design that stored the routed views instead of deriving them would return stale data after a steering write. A design that built its outputs from the current register values would lag one extra clock behind the source vector. A decoder that ignored the low offset bits would alias misaligned accesses onto real registers and corrupt the enable or steering word.

// File: rtl/irq_steer_pkg.sv
// Package: shared constants and types for the steering interrupt controller.
// Assumes byte offsets on a word-wide bus; all register offsets are word aligned.
package irq_steer_pkg;

    localparam int NSRC_DEF  = 32;
    localparam int ADDR_DEF  = 6;

    // register byte offsets (decoded by software, so fixed)
    localparam logic [7:0] OFF_IRQ_VIEW = 8'h00;
    localparam logic [7:0] OFF_ENABLE   = 8'h04;
    localparam logic [7:0] OFF_STEER    = 8'h08;
    localparam logic [7:0] OFF_CTRL     = 8'h0C;
    localparam logic [7:0] OFF_FIQ_VIEW = 8'h10;
    localparam logic [7:0] OFF_RAW      = 8'h20;

    // fixed system source positions
    localparam int SRC_RTC_ALARM  = 31;
    localparam int SRC_RTC_TICK   = 30;
    localparam int SRC_TMR_MATCH0 = 26;
    localparam int SRC_UART       = 17;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_IRQ_VIEW,
        RSEL_ENABLE,
        RSEL_STEER,
        RSEL_CTRL,
        RSEL_FIQ_VIEW,
        RSEL_RAW
    } reg_sel_e;

endpackage

// File: rtl/irq_bus_decode.sv
// Module: irq_bus_decode
// Maps a byte offset onto a register selector. Offsets outside the map and
// misaligned offsets select nothing. Purely combinational.
module irq_bus_decode
    import irq_steer_pkg::*;
#(
    parameter int ADDR_W = ADDR_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Purpose: full-width compare of the offset against each mapped register.
    always_comb begin
        if      (addr == ADDR_W'(OFF_IRQ_VIEW)) sel = RSEL_IRQ_VIEW;
        else if (addr == ADDR_W'(OFF_ENABLE))   sel = RSEL_ENABLE;
        else if (addr == ADDR_W'(OFF_STEER))    sel = RSEL_STEER;
        else if (addr == ADDR_W'(OFF_CTRL))     sel = RSEL_CTRL;
        else if (addr == ADDR_W'(OFF_FIQ_VIEW)) sel = RSEL_FIQ_VIEW;
        else if (addr == ADDR_W'(OFF_RAW))      sel = RSEL_RAW;
        else                                    sel = RSEL_NONE;
    end

endmodule

// File: rtl/irq_src_sample.sv
// Module: irq_src_sample
// Captures the level source vector into the raw pending register on every
// clock. Assumes sources are already synchronous to clk.
module irq_src_sample #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    output logic [NSRC-1:0] pend_q
);

    // Purpose: reload raw pending from the sources each cycle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= src_i;
    end

endmodule

// File: rtl/irq_cfg_regs.sv
// Module: irq_cfg_regs
// Holds the enable, steering and control words. Exposes both the stored
// values and the values they take at the coming edge (next-state), so the
// output stage can register the requests without an extra cycle of lag.
// Assumes at most one write strobe is active per cycle.
module irq_cfg_regs #(
    parameter int NSRC   = 32,
    parameter int CTRL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enable,
    input  logic              wr_steer,
    input  logic              wr_ctrl,
    input  logic [NSRC-1:0]   wdata,
    output logic [NSRC-1:0]   enable_q,
    output logic [NSRC-1:0]   steer_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [NSRC-1:0]   enable_d,
    output logic [NSRC-1:0]   steer_d
);

    // Purpose: next-state selection for the two routing words.
    always_comb begin
        enable_d = wr_enable ? wdata : enable_q;
        steer_d  = wr_steer  ? wdata : steer_q;
    end

    // Purpose: store the routing words, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            steer_q  <= '0;
        end else begin
            enable_q <= enable_d;
            steer_q  <= steer_d;
        end
    end

    // Purpose: store the control word, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
    end

    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |=> $stable(enable_q)); // R6
    AST_STEER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_steer |=> $stable(steer_q)); // R6

endmodule

// File: rtl/irq_route_out.sv
// Module: irq_route_out
// Forms the normal and fast routed views from stored state (read views), and
// registers the two request lines from next-state values so that they track
// the views with no extra cycle.
module irq_route_out #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend_q,
    input  logic [NSRC-1:0] enable_q,
    input  logic [NSRC-1:0] steer_q,
    input  logic [NSRC-1:0] pend_d,
    input  logic [NSRC-1:0] enable_d,
    input  logic [NSRC-1:0] steer_d,
    output logic [NSRC-1:0] irq_view,
    output logic [NSRC-1:0] fiq_view,
    output logic            irq_o,
    output logic            fiq_o
);

    logic [NSRC-1:0] live_d;

    // Purpose: routed views derived at read time from stored state.
    always_comb begin
        irq_view = enable_q & pend_q & ~steer_q;
        fiq_view = enable_q & pend_q &  steer_q;
        live_d   = enable_d & pend_d;
    end

    // Purpose: register the request lines from the coming-edge values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(live_d & ~steer_d);
            fiq_o <= |(live_d &  steer_d);
        end
    end

    AST_IRQ_TRACKS_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|irq_view)); // R5
    AST_FIQ_TRACKS_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == (|fiq_view)); // R5

endmodule

// File: rtl/irq_steer_ctrl.sv
// Module: irq_steer_ctrl (top)
// Steering interrupt controller: samples level sources, gates them with an
// enable word and steers each bit to the normal or fast request line.
// Assumes a single-cycle register bus; read data is combinational.
module irq_steer_ctrl
    import irq_steer_pkg::*;
#(
    parameter int NSRC   = NSRC_DEF,
    parameter int ADDR_W = ADDR_DEF,
    parameter int CTRL_W = NSRC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    reg_sel_e          sel;
    logic              wr_go;
    logic              rd_go;
    logic [NSRC-1:0]   pend_q;
    logic [NSRC-1:0]   enable_q;
    logic [NSRC-1:0]   steer_q;
    logic [NSRC-1:0]   enable_d;
    logic [NSRC-1:0]   steer_d;
    logic [CTRL_W-1:0] ctrl_q;
    logic [NSRC-1:0]   ctrl_rd;
    logic [NSRC-1:0]   irq_view;
    logic [NSRC-1:0]   fiq_view;

    irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Purpose: qualify bus strobes.
    always_comb begin
        wr_go = bus_sel &  bus_we;
        rd_go = bus_sel & ~bus_we;
    end

    irq_src_sample #(.NSRC(NSRC)) u_sample (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .pend_q (pend_q)
    );

    irq_cfg_regs #(.NSRC(NSRC), .CTRL_W(CTRL_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_enable (wr_go && sel == RSEL_ENABLE),
        .wr_steer  (wr_go && sel == RSEL_STEER),
        .wr_ctrl   (wr_go && sel == RSEL_CTRL),
        .wdata     (bus_wdata),
        .enable_q  (enable_q),
        .steer_q   (steer_q),
        .ctrl_q    (ctrl_q),
        .enable_d  (enable_d),
        .steer_d   (steer_d)
    );

    irq_route_out #(.NSRC(NSRC)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_q   (pend_q),
        .enable_q (enable_q),
        .steer_q  (steer_q),
        .pend_d   (src_i),
        .enable_d (enable_d),
        .steer_d  (steer_d),
        .irq_view (irq_view),
        .fiq_view (fiq_view),
        .irq_o    (irq_o),
        .fiq_o    (fiq_o)
    );

    // Purpose: widen the control word to the bus width.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CTRL_W-1:0] = ctrl_q;
    end

    // Purpose: read-data multiplexer, zero when no read is selected.
    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            case (sel)
                RSEL_IRQ_VIEW: bus_rdata = irq_view;
                RSEL_ENABLE:   bus_rdata = enable_q;
                RSEL_STEER:    bus_rdata = steer_q;
                RSEL_CTRL:     bus_rdata = ctrl_rd;
                RSEL_FIQ_VIEW: bus_rdata = fiq_view;
                RSEL_RAW:      bus_rdata = pend_q;
                default:       bus_rdata = '0;
            endcase
        end
    end

    AST_VIEW_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && (sel == RSEL_IRQ_VIEW || sel == RSEL_FIQ_VIEW || sel == RSEL_RAW)
        |=> $stable(enable_q) && $stable(steer_q) && $stable(ctrl_q)); // R7
    AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && sel == RSEL_NONE
        |=> $stable(enable_q) && $stable(steer_q) && $stable(ctrl_q)); // R8
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |-> bus_rdata == '0); // R8

endmodule

// File: tb/tb_irq_steer_ctrl.sv
`timescale 1ns/100ps
module tb_irq_steer_ctrl;

    localparam int NSRC = 32;
    localparam int AW   = 6;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] src_i;
    logic            bus_sel;
    logic            bus_we;
    logic [AW-1:0]   bus_addr;
    logic [NSRC-1:0] bus_wdata;
    logic [NSRC-1:0] bus_rdata;
    logic            irq_o;
    logic            fiq_o;

    int n_chk  = 0;
    int n_fail = 0;

    // model state
    logic [31:0] m_en, m_st, m_ctl, m_pend;

    irq_steer_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #4 clk = ~clk;  // 125 MHz

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        case (a)
            6'h00:   return m_en & m_pend & ~m_st;
            6'h04:   return m_en;
            6'h08:   return m_st;
            6'h0C:   return m_ctl;
            6'h10:   return m_en & m_pend & m_st;
            6'h20:   return m_pend;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] a);
        case (a)
            6'h00:   return "R3";
            6'h04, 6'h08, 6'h0C: return "R6 R7";
            6'h10:   return "R4";
            6'h20:   return "R2 R9";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [5:0] pick_addr(input int k);
        case (k)
            0: return 6'h00;  1: return 6'h04;  2: return 6'h08;
            3: return 6'h0C;  4: return 6'h10;  5: return 6'h20;
            6: return 6'h14;  7: return 6'h24;  8: return 6'h05;
            default: return 6'h3C;
        endcase
    endfunction

    // one clock: drive sources and an optional write, update the model
    task automatic step(input logic [31:0] s, input logic wr, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        src_i = s; bus_sel = wr; bus_we = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
        m_pend = s;
        if (wr) begin
            if (a == 6'h04) m_en  = d;
            if (a == 6'h08) m_st  = d;
            if (a == 6'h0C) m_ctl = d;
        end
    endtask

    // read every mapped word plus one unmapped offset, check outputs
    task automatic check_all(input logic [5:0] gap);
        logic [31:0] ei, ef;
        ei = m_en & m_pend & ~m_st;
        ef = m_en & m_pend & m_st;
        check("R5 irq_o", {31'b0, irq_o}, {31'b0, |ei});
        check("R5 fiq_o", {31'b0, fiq_o}, {31'b0, |ef});
        check("R8 idle rdata", bus_rdata, 32'h0);
        for (int k = 0; k < 7; k++) begin
            logic [5:0] a;
            a = (k == 6) ? gap : pick_addr(k);
            bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
            #0.4;
            check(req_of(a), bus_rdata, exp_read(a));
        end
        bus_sel = 1'b0;
    endtask

    initial begin
        #(8.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; src_i = '1; bus_sel = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        m_en = 0; m_st = 0; m_ctl = 0; m_pend = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state (sources high during reset still give zero pending)
        check("R1 irq_o", {31'b0, irq_o}, 32'h0);
        check("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
        bus_sel = 1'b1; bus_addr = 6'h20; #0.4; check("R1 raw", bus_rdata, 32'h0);
        bus_addr = 6'h04; #0.4; check("R1 enable", bus_rdata, 32'h0);
        bus_addr = 6'h08; #0.4; check("R1 steer", bus_rdata, 32'h0);
        bus_addr = 6'h0C; #0.4; check("R1 ctrl", bus_rdata, 32'h0);
        bus_sel = 1'b0;
        @(negedge clk); rst_n = 1'b1; src_i = '0;
        @(posedge clk); #1;

        // directed: all enabled, all steered normal, then all fast, then masked
        step('1, 1'b1, 6'h04, '1);           check_all(6'h14);
        step('1, 1'b0, 6'h00, 0);            check_all(6'h18);
        step('1, 1'b1, 6'h08, '1);           check_all(6'h1C);
        step('1, 1'b1, 6'h04, 32'h0);        check_all(6'h3C);
        // R9: fixed positions steered individually
        step(32'h0, 1'b1, 6'h04, '1);        check_all(6'h14);
        step(32'h0, 1'b1, 6'h08, 32'h8000_0000); check_all(6'h14);
        for (int b = 0; b < 7; b++) begin
            int pos;
            pos = (b == 0) ? 31 : (b == 1) ? 30 : (b == 6) ? 17 : 24 + b;
            step(32'h1 << pos, 1'b0, 6'h00, 0); check_all(6'h24);
        end
        // R7 / R8: writes to views, gaps and misaligned offsets
        step(32'h0002_0000, 1'b1, 6'h00, '1); check_all(6'h05);
        step(32'h0002_0000, 1'b1, 6'h10, '1); check_all(6'h05);
        step(32'h0002_0000, 1'b1, 6'h20, '1); check_all(6'h05);
        step(32'h0002_0000, 1'b1, 6'h05, 32'h0); check_all(6'h09);
        step(32'h0002_0000, 1'b1, 6'h09, 32'h0); check_all(6'h0D);
        step(32'h0002_0000, 1'b1, 6'h24, 32'h0); check_all(6'h06);
        step(32'h0002_0000, 1'b1, 6'h0C, 32'hA5A5_5A5A); check_all(6'h24);

        // constrained random
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] s, d;
            logic        wr;
            logic [5:0]  a;
            s  = ($urandom_range(0, 3) == 0) ? ($urandom() & $urandom() & $urandom()) : $urandom();
            d  = $urandom();
            wr = ($urandom_range(0, 2) != 0);
            a  = pick_addr($urandom_range(0, 9));
            if ($urandom_range(0, 7) == 0) a = 6'($urandom());
            step(s, wr, a, d);
            check_all(pick_addr($urandom_range(6, 9)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule